// File: doc/BRIEF.md
# Keyed Watchdog Timer with Reset-Out Pulse

This block is a watchdog for a small processor core. A counter, 14 bits wide by default, advances by one on each machine-cycle strobe once the watchdog is armed. Out of reset the watchdog is off. Software turns it on by writing a two-byte key to one write-only address: first 1Eh, then E1h. Software keeps it from expiring by writing the same key again. No write can turn it off. Only a hardware reset or the watchdog's own expiry returns it to the off state. The counter cannot be read.

When the count would pass its all-ones value, the watchdog expires. It returns to the off state and raises a reset-out pulse that lasts a fixed number of oscillator clocks, 98 by default. A control input suppresses that pulse so the reset pin stays input-only. Two other conditions stop counting. Power-down always stops it. Idle stops it only when the idle-freeze control is set. After a power-down that ends through an interrupt, counting waits until the wake-up interrupt line has returned high.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset `rst_out` is 0 and the watchdog is off: machine-cycle strobes produce no pulse, however many arrive.
- R2: A write of 1Eh followed by a write of E1h, both to the service address (`SVC_ADDR`, default A6h), turns the watchdog on with its count at zero.
- R3: While on, the count rises by one on each `mc_tick`. Expiry happens on the 2^CW-th counted tick after the count was last cleared, never earlier.
- R4: On expiry `rst_out` goes high on the clock edge of the expiring tick. It stays high for exactly `PULSE_CLKS` clock cycles (default 98).
- R5: Expiry turns the watchdog off and clears the count. Further ticks produce no pulse until the key is written again.
- R6: While on, writing the key clears the count, so the next expiry comes 2^CW ticks after the service. No write sequence turns the watchdog off.
- R7: A write to the service address with any value other than E1h directly after 1Eh cancels the sequence, and the count is kept. An E1h with no 1Eh before it does nothing. A repeated 1Eh re-arms the sequence. Writes to other addresses are ignored and do not break a pending sequence.
- R8: With `rst_out_dis` = 1, expiry produces no pulse, but it still turns the watchdog off.
- R9: With `idle_freeze` = 1, ticks during `idle` are not counted, and counting resumes when idle ends. With `idle_freeze` = 0, idle has no effect on counting.
- R10: Ticks during `pdown` are not counted. After power-down, counting stays held while `wake_n` is 0 and resumes once `wake_n` is 1.
- R11: If the E1h key write and the tick that would expire the watchdog fall in the same cycle, the service wins: no pulse, the count is cleared, and the watchdog stays on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low hardware reset |
| mc_tick | input | 1 | Machine-cycle strobe, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| idle | input | 1 | Core is in idle mode |
| pdown | input | 1 | Core is in power-down mode |
| wake_n | input | 1 | Wake-up interrupt line, low while held |
| idle_freeze | input | 1 | 1: stop counting during idle |
| rst_out_dis | input | 1 | 1: suppress the reset-out pulse |
| rst_out | output | 1 | Reset-out pulse, active high |

## Verification
Two functions can fall in the same cycle: completion of the service key, and the tick that would expire the watchdog. The bench counts ticks until the count sits at all ones. It then writes 1Eh and issues E1h in the same cycle as a strobe. It judges the result at the ports: no pulse may follow, and the next pulse must arrive exactly 2^CW ticks later. A sweep of service points across the counting window confirms, with tick-exact arithmetic, that each service moves the expiry to the same distance.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int          CW         = 14,
  parameter int          PULSE_CLKS = 98,
  parameter logic [7:0]  SVC_ADDR   = 8'hA6,
  parameter logic [7:0]  KEY_A      = 8'h1E,
  parameter logic [7:0]  KEY_B      = 8'hE1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mc_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       idle,
  input  logic       pdown,
  input  logic       wake_n,
  input  logic       idle_freeze,
  input  logic       rst_out_dis,
  output logic       rst_out
);
  localparam int            PW      = $clog2(PULSE_CLKS + 1);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [PW-1:0] PULSE_V = PW'(PULSE_CLKS);

  logic          en_q, armed_q, hold_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pcnt_q;

  wire svc_wr   = wr_en && (wr_addr == SVC_ADDR);
  wire key_done = svc_wr && armed_q && (wr_data == KEY_B);
  wire run      = en_q && mc_tick && !pdown && !hold_q && !(idle && idle_freeze);
  wire ovf      = run && (cnt_q == CNT_MAX) && !key_done;

  assign rst_out = (pcnt_q != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      armed_q <= 1'b0;
    else if (ovf)    armed_q <= 1'b0;
    else if (svc_wr) armed_q <= (wr_data == KEY_A);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (key_done) begin
      en_q  <= 1'b1;
      cnt_q <= '0;
    end else if (ovf) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_q + CW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      hold_q <= 1'b0;
    else if (pdown)  hold_q <= 1'b1;
    else if (wake_n) hold_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    pcnt_q <= '0;
    else if (ovf && !rst_out_dis)  pcnt_q <= PULSE_V;
    else if (pcnt_q != '0)         pcnt_q <= pcnt_q - PW'(1);

  assert_key_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_done |=> (en_q && cnt_q == '0));

  assert_no_sw_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !ovf) |=> en_q);

  assert_off_after_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> !en_q);

  assert_suppressed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out_dis && !rst_out) |=> !rst_out);

  assert_idle_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && idle_freeze && !key_done) |=> $stable(cnt_q));

  assert_pdown_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pdown && !key_done) |=> $stable(cnt_q));

  assert_service_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (key_done && mc_tick && cnt_q == CNT_MAX) |=> (!$rose(rst_out) && en_q));
endmodule

// File: tb/keyed_watchdog_bench.sv
`timescale 1ns/1ps
module keyed_watchdog_bench;
  localparam int CW    = 10;
  localparam int PULSE = 98;
  localparam int LIM   = 1 << CW;
  localparam logic [7:0] SA = 8'hA6;

  logic clk = 0, rst_n = 0, mc_tick = 0, wr_en = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic idle = 0, pdown = 0, wake_n = 1, idle_freeze = 0, rst_out_dis = 0;
  logic rst_out;

  int n_chk = 0, n_bad = 0;
  int rises = 0, run_len = 0, last_len = 0, base = 0;
  logic prev_out = 0;

  always #5 clk = ~clk;

  keyed_watchdog #(.CW(CW), .PULSE_CLKS(PULSE)) u_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .idle(idle), .pdown(pdown),
    .wake_n(wake_n), .idle_freeze(idle_freeze), .rst_out_dis(rst_out_dis),
    .rst_out(rst_out));

  always @(negedge clk) begin
    if (rst_out && !prev_out) begin rises++; run_len = 1; end
    else if (rst_out) run_len++;
    else if (prev_out) last_len = run_len;
    prev_out = rst_out;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic new_rises(input string tag, input int exp);
    #1;
    chk(tag, rises - base, exp);
    base = rises;
  endtask

  task automatic tick(input int n);
    if (n > 0) begin
      @(negedge clk); mc_tick = 1;
      repeat (n) @(posedge clk);
      @(negedge clk); mc_tick = 0;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic key();
    wr(SA, 8'h1E); wr(SA, 8'hE1);
  endtask

  task automatic drain();
    repeat (PULSE + 5) @(negedge clk);
    #1; base = rises;
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset rst_out", rst_out, 0);
    rst_n = 1;
    tick(LIM + 50);
    new_rises("R1 off after reset", 0);

    key();
    tick(LIM - 1);
    new_rises("R3 no early expiry", 0);
    tick(1);
    chk("R4 pulse on expiring tick", rst_out, 1);
    new_rises("R2 key enables", 1);
    drain();
    chk("R4 pulse length", last_len, PULSE);

    tick(LIM + 50);
    new_rises("R5 off after expiry", 0);

    for (int k = 0; k < 10; k++) begin
      key();
      tick(k * 113 + 1);
      key();
      tick(LIM - 1);
      new_rises("R6 service clears count", 0);
      tick(1);
      new_rises("R6 expiry after service", 1);
      drain();
    end

    key();
    tick(300);
    wr(SA, 8'h1E); wr(SA, 8'h55); wr(SA, 8'hE1); wr(SA, 8'h00);
    tick(LIM - 300 - 1);
    new_rises("R7 aborted key keeps count", 0);
    tick(1);
    new_rises("R7 expiry without service", 1);
    drain();

    key();
    tick(300);
    wr(SA, 8'h1E); wr(8'h10, 8'hE1); wr(SA, 8'hE1);
    tick(LIM - 1);
    new_rises("R7 other address ignored", 0);
    tick(1);
    new_rises("R7 other address expiry", 1);
    drain();

    key();
    tick(200);
    wr(SA, 8'h1E); wr(SA, 8'h1E); wr(SA, 8'hE1);
    tick(LIM - 1);
    new_rises("R7 rearm by repeated 1E", 0);
    tick(1);
    new_rises("R7 rearm expiry", 1);
    drain();

    rst_out_dis = 1;
    key();
    tick(LIM + 5);
    chk("R8 suppressed rst_out", rst_out, 0);
    new_rises("R8 no pulse", 0);
    rst_out_dis = 0;
    tick(LIM + 5);
    new_rises("R8 still turned off", 0);

    key();
    tick(400);
    idle = 1; idle_freeze = 1;
    tick(3000);
    idle = 0;
    tick(LIM - 400 - 1);
    new_rises("R9 idle frozen", 0);
    tick(1);
    new_rises("R9 resume after idle", 1);
    drain();

    idle_freeze = 0; idle = 1;
    key();
    tick(LIM - 1);
    new_rises("R9 idle counts when not frozen", 0);
    tick(1);
    new_rises("R9 idle expiry", 1);
    idle = 0;
    drain();

    key();
    tick(500);
    pdown = 1; wake_n = 0;
    tick(2000);
    pdown = 0;
    tick(2000);
    new_rises("R10 held while wake low", 0);
    wake_n = 1;
    tick(LIM - 500 - 1);
    new_rises("R10 no early expiry", 0);
    tick(1);
    new_rises("R10 resume after wake", 1);
    drain();

    key();
    tick(LIM - 1);
    wr(SA, 8'h1E);
    @(negedge clk); wr_en = 1; wr_addr = SA; wr_data = 8'hE1; mc_tick = 1;
    @(negedge clk); wr_en = 0; mc_tick = 0;
    repeat (3) @(negedge clk);
    new_rises("R11 service wins tie", 0);
    tick(LIM - 1);
    new_rises("R11 count cleared", 0);
    tick(1);
    new_rises("R11 later expiry", 1);
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule